// File: doc/BRIEF.md
# Processor Reset and Strap Sequencer

This block turns an asynchronous, active-low platform reset into the processor's active-low reset. It holds the processor reset for a programmable number of bus-clock cycles after the platform reset is released. The same sequencer drives a configuration strap pin. The strap is held at its configured level during reset, kept there for a bounded number of cycles after the processor reset lifts, and then released by dropping the pin's output enable.

The platform reset passes through a two-stage synchronizer. Its assertion takes effect at once, without waiting for a clock. Its release reaches the sequencer on the second rising clock edge. If the platform reset is asserted at any point, even between two clock edges, the sequence starts again from the beginning. A completion flag tells the platform when the strap pin has been released and the sequence is finished.

Top module: `rstseq_top`

## Requirements
- R1: Within the same time step as plat_rst_n falling, with no clock edge needed, core_rst_n is 0, strap_en is 1, strap_drv is STRAP_LEVEL and seq_done is 0.
- R2: core_rst_n stays 0 on every cycle during which plat_rst_n is held low.
- R3: Edges are numbered from 1, starting with the first rising bus_clk edge at which plat_rst_n is high. core_rst_n becomes 1 at edge STRETCH_CYCLES+2: two synchronizer edges plus the stretch.
- R4: Whenever core_rst_n is 0, strap_en is 1 and strap_drv equals STRAP_LEVEL. STRAP_LEVEL defaults to 0, which drives the pin low.
- R5: strap_en has been 1 for at least SETUP_MIN (4) consecutive cycles before the edge on which core_rst_n rises. A STRETCH_CYCLES below SETUP_MIN is rejected at elaboration.
- R6: strap_en falls exactly HOLD_CYCLES rising edges after core_rst_n rises. HOLD_CYCLES must lie in 2..20; other values are rejected at elaboration.
- R7: seq_done rises on the same edge on which strap_en falls, and stays 1 until the next reset. While strap_en is 0, strap_drv is 0.
- R8: If plat_rst_n is asserted during the stretch, during the hold or after completion, the next release repeats the full R3/R6 timing from edge 1. This includes a pulse that falls between two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| plat_rst_n | input | 1 | Asynchronous active-low platform reset |
| core_rst_n | output | 1 | Active-low processor reset |
| strap_drv | output | 1 | Value driven onto the strap pin |
| strap_en | output | 1 | Output enable of the strap pin; 0 means three-stated |
| seq_done | output | 1 | Strap released, sequence complete |

## Verification
The asynchronous restart can land in the same cycle as a timed event: the stretch expiring, the hold expiring, or the synchronizer releasing. The bench drops plat_rst_n just before the edge on which core_rst_n would rise or strap_en would fall. It also drops plat_rst_n for a few nanoseconds between edges. A behavioural edge-count model predicts every output on every cycle, and the bench judges that the restart wins and the full timing repeats. Three instances with different stretch and hold lengths run in parallel, so the hold's lower and upper bounds and the minimum stretch are covered.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    SEQ_STRETCH = 2'd0,
    SEQ_HOLD    = 2'd1,
    SEQ_DONE    = 2'd2
  } seq_state_t;

  function automatic int cnt_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return $clog2(m + 1);
  endfunction
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_o = ~pipe_q[STAGES-1];
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  assign hit = run && (cnt_q == limit - W'(1));

  always_ff @(posedge clk or posedge clr) begin
    if (clr)      cnt_q <= '0;
    else if (hit) cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter logic STRAP_LEVEL = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stretch_hit,
  input  logic       hold_hit,
  output seq_state_t state,
  output logic       core_rst_n,
  output logic       strap_drv,
  output logic       strap_en,
  output logic       done
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state      <= SEQ_STRETCH;
      core_rst_n <= 1'b0;
      strap_drv  <= STRAP_LEVEL;
      strap_en   <= 1'b1;
      done       <= 1'b0;
    end else begin
      case (state)
        SEQ_STRETCH: if (stretch_hit) begin
          state      <= SEQ_HOLD;
          core_rst_n <= 1'b1;
        end
        SEQ_HOLD: if (hold_hit) begin
          state     <= SEQ_DONE;
          strap_en  <= 1'b0;
          strap_drv <= 1'b0;
          done      <= 1'b1;
        end
        default: state <= SEQ_DONE;
      endcase
    end
  end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int   STRETCH_CYCLES = 100000,
  parameter int   HOLD_CYCLES    = 10,
  parameter int   SETUP_MIN      = 4,
  parameter logic STRAP_LEVEL    = 1'b0
) (
  input  logic bus_clk,
  input  logic plat_rst_n,
  output logic core_rst_n,
  output logic strap_drv,
  output logic strap_en,
  output logic seq_done
);
  localparam int W = cnt_width(STRETCH_CYCLES, HOLD_CYCLES);
  localparam logic [W-1:0] STRETCH_L = W'(STRETCH_CYCLES);
  localparam logic [W-1:0] HOLD_L    = W'(HOLD_CYCLES);

  generate
    if (HOLD_CYCLES < 2 || HOLD_CYCLES > 20) begin : g_bad_hold
      $error("HOLD_CYCLES must lie in 2..20");
    end
    if (STRETCH_CYCLES < SETUP_MIN) begin : g_bad_stretch
      $error("STRETCH_CYCLES must be at least SETUP_MIN");
    end
  endgenerate

  logic       rst_s;
  logic       hit;
  seq_state_t state;
  logic       run;
  logic [W-1:0] limit;

  rstseq_sync #(.STAGES(2)) u_sync (
    .clk(bus_clk), .arst_n(plat_rst_n), .rst_o(rst_s)
  );

  assign run   = (state != SEQ_DONE);
  assign limit = (state == SEQ_STRETCH) ? STRETCH_L : HOLD_L;

  rstseq_timer #(.W(W)) u_timer (
    .clk(bus_clk), .clr(rst_s), .run(run), .limit(limit), .hit(hit)
  );

  rstseq_fsm #(.STRAP_LEVEL(STRAP_LEVEL)) u_fsm (
    .clk(bus_clk), .rst(rst_s),
    .stretch_hit(hit && state == SEQ_STRETCH),
    .hold_hit(hit && state == SEQ_HOLD),
    .state(state), .core_rst_n(core_rst_n), .strap_drv(strap_drv),
    .strap_en(strap_en), .done(seq_done)
  );

  // Window counters used only by the checks below
  logic [W:0] stretch_seen, hold_seen;
  always_ff @(posedge bus_clk or posedge rst_s) begin
    if (rst_s) begin
      stretch_seen <= '0;
      hold_seen    <= '0;
    end else begin
      if (!core_rst_n)            stretch_seen <= stretch_seen + 1'b1;
      if (core_rst_n && strap_en) hold_seen    <= hold_seen + 1'b1;
    end
  end

  // R3
  stretch_len_chk: assert property (@(posedge bus_clk) disable iff (rst_s)
    $rose(core_rst_n) |-> stretch_seen == (W+1)'(STRETCH_CYCLES));
  // R4
  strap_in_reset_chk: assert property (@(posedge bus_clk) disable iff (rst_s)
    !core_rst_n |-> (strap_en && strap_drv == STRAP_LEVEL));
  // R5
  strap_setup_chk: assert property (@(posedge bus_clk) disable iff (rst_s)
    $rose(core_rst_n) |-> ($past(strap_en, 1) && $past(strap_en, 4)));
  // R6
  hold_len_chk: assert property (@(posedge bus_clk) disable iff (rst_s)
    $fell(strap_en) |-> (core_rst_n && hold_seen == (W+1)'(HOLD_CYCLES)));
  // R7
  done_state_chk: assert property (@(posedge bus_clk) disable iff (rst_s)
    seq_done |-> (core_rst_n && !strap_en && !strap_drv));
endmodule

// File: tb/sim_rstseq_top.sv
module sim_rstseq_top;
  localparam int S0 = 12, H0 = 5;
  localparam int S1 = 4,  H1 = 20;
  localparam int S2 = 6,  H2 = 2;

  logic bus_clk = 1'b0;
  logic plat_rst_n = 1'b0;
  always #5 bus_clk = ~bus_clk;

  logic [2:0] c, v, o, d;

  rstseq_top #(.STRETCH_CYCLES(S0), .HOLD_CYCLES(H0)) u0 (
    .bus_clk(bus_clk), .plat_rst_n(plat_rst_n), .core_rst_n(c[0]),
    .strap_drv(v[0]), .strap_en(o[0]), .seq_done(d[0]));
  rstseq_top #(.STRETCH_CYCLES(S1), .HOLD_CYCLES(H1)) u1 (
    .bus_clk(bus_clk), .plat_rst_n(plat_rst_n), .core_rst_n(c[1]),
    .strap_drv(v[1]), .strap_en(o[1]), .seq_done(d[1]));
  rstseq_top #(.STRETCH_CYCLES(S2), .HOLD_CYCLES(H2)) u2 (
    .bus_clk(bus_clk), .plat_rst_n(plat_rst_n), .core_rst_n(c[2]),
    .strap_drv(v[2]), .strap_en(o[2]), .seq_done(d[2]));

  int checks = 0, errors = 0;
  bit finished = 0;
  string ctx = "";

  // Reference: rising edges seen with the platform reset high since the last assertion
  int n = 0;
  always @(posedge bus_clk or negedge plat_rst_n) begin
    if (!plat_rst_n) n <= 0;
    else if (n < 100000) n <= n + 1;
  end

  int streak [3] = '{0, 0, 0};
  logic [2:0] prev_c = 3'b000;

  task automatic chk(input bit ok, input string tag, input int i,
                     input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s%s u%0d n=%0d: actual=%b expected=%b", tag, ctx, i, n, act, exp);
    end
  endtask

  task automatic cmp_all();
    int s [3] = '{S0, S1, S2};
    int h [3] = '{H0, H1, H2};
    for (int i = 0; i < 3; i++) begin
      logic ec, eo, ed;
      ec = (n >= s[i] + 2);
      eo = (n <  s[i] + 2 + h[i]);
      ed = !eo;
      chk(c[i] === ec, (n < 2) ? "R2" : "R3", i, c[i], ec);
      chk(o[i] === eo, ec ? "R6" : "R4", i, o[i], eo);
      chk(v[i] === 1'b0, eo ? "R4" : "R7", i, v[i], 1'b0);
      chk(d[i] === ed, "R7", i, d[i], ed);
    end
  endtask

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge bus_clk) begin
    if (!finished) begin
      cmp_all();
      for (int i = 0; i < 3; i++) begin
        if (!prev_c[i] && c[i] === 1'b1)
          chk(streak[i] >= 4, "R5", i, 1'b0, 1'b1);
        streak[i] = (o[i] === 1'b1) ? streak[i] + 1 : 0;
      end
      prev_c = c;
    end
  end

  task automatic cycles(input int k);
    repeat (k) @(negedge bus_clk);
  endtask

  task automatic drop_now(input string why);
    plat_rst_n = 1'b0;
    #1;
    ctx = why;
    for (int i = 0; i < 3; i++) begin
      chk(c[i] === 1'b0, "R1", i, c[i], 1'b0);
      chk(o[i] === 1'b1, "R1", i, o[i], 1'b1);
      chk(v[i] === 1'b0, "R1", i, v[i], 1'b0);
      chk(d[i] === 1'b0, "R1", i, d[i], 1'b0);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    cycles(5);                               // R2 reset held
    #2 plat_rst_n = 1'b1;  cycles(40);       // full sequence, all instances finish
    #2 drop_now(" R8 after done");  cycles(3);
    #2 plat_rst_n = 1'b1;  cycles(8);        // u0 mid-stretch
    #2 drop_now(" R8 mid stretch"); cycles(2);
    #2 plat_rst_n = 1'b1;  cycles(13);       // u0 last cycle before release edge
    #2 drop_now(" R8 at release edge"); cycles(2);
    #2 plat_rst_n = 1'b1;  cycles(16);       // u0 mid-hold, u1 mid-hold
    #2 drop_now(" R8 mid hold"); cycles(2);
    #2 plat_rst_n = 1'b1;  cycles(18);       // u0 right before strap release
    #2 drop_now(" R8 at strap release"); cycles(1);
    #2 plat_rst_n = 1'b1;  cycles(40);
    #2 drop_now(" R8 glitch");                // short pulse between edges
    #1 plat_rst_n = 1'b1;  cycles(40);
    ctx = "";
    summary();
  end
endmodule